// File: doc/BRIEF.md
# Flash Write Protection Gate

This block sits between the command decoder of a serial flash device and its array programming engine. For every program, erase or configuration-write request it decides whether the operation may proceed, and it answers with a single-cycle grant or reject pulse one clock after the request.

A write is granted only when three checks agree:

- A software write-enable latch is set. It is set and cleared by dedicated commands, and it clears itself after every request.
- The active-low hardware write-protect pin is released.
- For program and erase, the target address lies outside the protected region selected by a 3-bit range code.

A one-time-programmable lock input freezes the configuration. While it is set, every configuration write is refused, so the range code can no longer change.

Top module: `flash_wr_guard`

## Requirements
- R1: A pulse on `wren_i` sets `wel_o` on the next cycle, and a pulse on `wrdis_i` clears it. When both are high together, `wrdis_i` wins.
- R2: While `rst_ni` is low and right after its release, `wel_o`, `grant_o` and `reject_o` are 0.
- R3: A cycle with at least one of `prog_i`, `erase_i` or `cfg_wr_i` high is a request.
  - Each request produces exactly one of `grant_o` or `reject_o`, high for one cycle, on the cycle after the request.
  - With no request, both outputs stay low.
- R4: A request made while `wel_o` is 0 is rejected.
- R5: A request made while `wp_ni` is 0 is rejected, whatever the latch holds.
- R6: `range_i` selects the protected region of program and erase requests (`addr_i` is `ADDR_W` bits wide).
  - Code 0 protects nothing, and code 7 protects every address.
  - A code k from 1 to 6 protects the top 2^(k-7) of the space, which are the addresses whose upper 7-k bits are all ones.
  - A program or erase to a protected address is rejected.
- R7: A configuration write ignores `addr_i` and `range_i`. It is rejected whenever `otp_lock_i` is 1, even with the latch set and the pin released.
- R8: `wel_o` is 0 on the cycle after any request, whether granted or rejected. It stays 0 even when `wren_i` was high in the same cycle.
- R9: A cycle with more than one of `prog_i`, `erase_i` and `cfg_wr_i` high produces a single reject.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Write-enable command strobe |
| wrdis_i | input | 1 | Write-disable command strobe |
| prog_i | input | 1 | Program request strobe |
| erase_i | input | 1 | Erase request strobe |
| cfg_wr_i | input | 1 | Configuration-write request strobe |
| addr_i | input | ADDR_W | Target address of program or erase |
| wp_ni | input | 1 | Hardware write-protect pin, active low |
| range_i | input | 3 | Protected-range code |
| otp_lock_i | input | 1 | One-time-programmable lock |
| grant_o | output | 1 | Request granted, one-cycle pulse |
| reject_o | output | 1 | Request refused, one-cycle pulse |
| wel_o | output | 1 | Write-enable latch state |

## Verification
Random sequences mix latch commands, pin levels, lock states, range codes and addresses. Half the addresses are biased into the upper region, so that each range boundary is reached from both sides. This separates a reject caused by the latch from one caused by the pin or the range.

Directed cases cover the following:
- Addresses exactly one below and exactly at the protected boundary for each code, which separates the correct threshold from an off-by-one.
- Configuration writes to protected addresses, which show that the address is ignored.
- A set and a clear in the same cycle, and a set together with a request, which expose the latch priority.
- Stacked request strobes.

// File: rtl/flash_wr_guard_pkg.sv
package flash_wr_guard_pkg;
  localparam int unsigned RANGE_W     = 3;
  localparam int unsigned RANGE_CODES = 1 << RANGE_W;

  typedef enum logic [2:0] {
    REQ_NONE  = 3'd0,
    REQ_PROG  = 3'd1,
    REQ_ERASE = 3'd2,
    REQ_CFG   = 3'd3,
    REQ_MULTI = 3'd4
  } req_kind_e;

  typedef struct packed {
    logic wren;
    logic wrdis;
    logic prog;
    logic erase;
    logic cfg;
  } cmd_t;
endpackage

// File: rtl/fwg_req_classify.sv
module fwg_req_classify
  import flash_wr_guard_pkg::*;
(
  input  cmd_t      cmd_i,
  output req_kind_e kind_o,
  output logic      any_req_o
);
  logic [2:0] strobes;
  logic [1:0] n_strobes;

  assign strobes   = {cmd_i.cfg, cmd_i.erase, cmd_i.prog};
  assign n_strobes = 2'(strobes[0]) + 2'(strobes[1]) + 2'(strobes[2]);
  assign any_req_o = |strobes;

  always_comb begin
    kind_o = REQ_NONE;
    if (n_strobes > 2'd1)  kind_o = REQ_MULTI;
    else if (cmd_i.prog)   kind_o = REQ_PROG;
    else if (cmd_i.erase)  kind_o = REQ_ERASE;
    else if (cmd_i.cfg)    kind_o = REQ_CFG;
  end
endmodule

// File: rtl/fwg_range_check.sv
module fwg_range_check
  import flash_wr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [RANGE_W-1:0] range_i,
  output logic               hit_o
);
  localparam int unsigned TOP_CODE = RANGE_CODES - 1;

  logic [RANGE_CODES-1:0] code_hit;

  assign code_hit[0]        = 1'b0;
  assign code_hit[TOP_CODE] = 1'b1;

  // code k covers the region where the upper (TOP_CODE-k) address bits are all ones
  for (genvar k = 1; k < TOP_CODE; k++) begin : g_code
    localparam int unsigned W = TOP_CODE - k;
    assign code_hit[k] = &addr_i[ADDR_W-1 -: W];
  end

  assign hit_o = code_hit[range_i];
endmodule

// File: rtl/fwg_wel_latch.sv
module fwg_wel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic consume_i,
  output logic wel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wel_o <= 1'b0;
    else if (consume_i || clr_i) wel_o <= 1'b0;
    else if (set_i)             wel_o <= 1'b1;
  end
endmodule

// File: rtl/fwg_verdict.sv
module fwg_verdict
  import flash_wr_guard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  req_kind_e kind_i,
  input  logic      wel_i,
  input  logic      wp_ni,
  input  logic      range_hit_i,
  input  logic      otp_lock_i,
  output logic      grant_o,
  output logic      reject_o
);
  logic layer_ok;
  logic allow;

  assign layer_ok = wel_i && wp_ni;

  always_comb begin
    unique case (kind_i)
      REQ_PROG, REQ_ERASE: allow = layer_ok && !range_hit_i;
      REQ_CFG:             allow = layer_ok && !otp_lock_i;
      default:             allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      grant_o  <= (kind_i != REQ_NONE) && allow;
      reject_o <= (kind_i != REQ_NONE) && !allow;
    end
  end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import flash_wr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wren_i,
  input  logic               wrdis_i,
  input  logic               prog_i,
  input  logic               erase_i,
  input  logic               cfg_wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wp_ni,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               otp_lock_i,
  output logic               grant_o,
  output logic               reject_o,
  output logic               wel_o
);
  cmd_t      cmd;
  req_kind_e kind;
  logic      any_req;
  logic      range_hit;

  assign cmd = '{wren: wren_i, wrdis: wrdis_i, prog: prog_i, erase: erase_i, cfg: cfg_wr_i};

  fwg_req_classify u_classify (
    .cmd_i     (cmd),
    .kind_o    (kind),
    .any_req_o (any_req)
  );

  fwg_range_check #(.ADDR_W(ADDR_W)) u_range (
    .addr_i  (addr_i),
    .range_i (range_i),
    .hit_o   (range_hit)
  );

  fwg_wel_latch u_wel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (cmd.wren),
    .clr_i     (cmd.wrdis),
    .consume_i (any_req),
    .wel_o     (wel_o)
  );

  fwg_verdict u_verdict (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kind_i      (kind),
    .wel_i       (wel_o),
    .wp_ni       (wp_ni),
    .range_hit_i (range_hit),
    .otp_lock_i  (otp_lock_i),
    .grant_o     (grant_o),
    .reject_o    (reject_o)
  );
endmodule

// File: rtl/flash_wr_guard_chk.sv
module flash_wr_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wren_i,
  input logic wrdis_i,
  input logic prog_i,
  input logic erase_i,
  input logic cfg_wr_i,
  input logic wp_ni,
  input logic otp_lock_i,
  input logic grant_o,
  input logic reject_o,
  input logic wel_o
);
  logic req;
  assign req = prog_i || erase_i || cfg_wr_i;

  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o)); // R3
  AST_REQ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> (grant_o || reject_o)); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |=> !(grant_o || reject_o)); // R3
  AST_LATCH_REQUIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !wel_o) |=> !grant_o); // R4
  AST_PIN_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !wp_ni) |=> !grant_o); // R5
  AST_LOCK_BLOCKS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && otp_lock_i) |=> !grant_o); // R7
  AST_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> !wel_o); // R8
  AST_WEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !wrdis_i && !req) |=> wel_o); // R1
  AST_WEL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrdis_i |=> !wel_o); // R1
  AST_MULTI_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({prog_i, erase_i, cfg_wr_i}) > 1) |=> reject_o); // R9
endmodule

bind flash_wr_guard flash_wr_guard_chk u_chk (.*);

// File: tb/flash_wr_guard_bench.sv
module flash_wr_guard_bench;
  localparam int unsigned ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wren = 0, wrdis = 0, prog = 0, erase = 0, cfg = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wp_n = 1'b1;
  logic [2:0]        rng = '0;
  logic              lock = 1'b0;
  logic              grant, reject, wel;

  int n_chk = 0;
  int n_fail = 0;
  bit ref_wel = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_wr_guard #(.ADDR_W(ADDR_W)) u_flash_wr_guard (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdis_i(wrdis),
    .prog_i(prog), .erase_i(erase), .cfg_wr_i(cfg), .addr_i(addr),
    .wp_ni(wp_n), .range_i(rng), .otp_lock_i(lock),
    .grant_o(grant), .reject_o(reject), .wel_o(wel)
  );

  function automatic bit in_range(logic [ADDR_W-1:0] a, logic [2:0] c);
    longint unsigned span;
    if (c == 3'd0) return 1'b0;
    if (c == 3'd7) return 1'b1;
    span = longint'(1) << (ADDR_W - 7 + c);
    return longint'(a) >= ((longint'(1) << ADDR_W) - span);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then check the registered response
  task automatic step(bit i_wren, bit i_wrdis, bit i_prog, bit i_erase, bit i_cfg,
                      logic [ADDR_W-1:0] i_addr, bit i_wp_n, logic [2:0] i_rng, bit i_lock);
    int  n_req;
    bit  ok;
    bit  req;
    bit  exp_wel;
    string tag;
    @(negedge clk);
    wren = i_wren; wrdis = i_wrdis; prog = i_prog; erase = i_erase; cfg = i_cfg;
    addr = i_addr; wp_n = i_wp_n; rng = i_rng; lock = i_lock;
    n_req = int'(i_prog) + int'(i_erase) + int'(i_cfg);
    req = n_req > 0;
    ok = ref_wel && i_wp_n;
    if (n_req > 1)   begin ok = 1'b0; tag = "R9"; end
    else if (i_cfg)  begin ok = ok && !i_lock; tag = "R7"; end
    else if (!i_wp_n) tag = "R5";
    else if (!ref_wel) tag = "R4";
    else begin ok = ok && !in_range(i_addr, i_rng); tag = "R6"; end
    if (!req) tag = "R3";
    if (req || i_wrdis) exp_wel = 1'b0;
    else if (i_wren)    exp_wel = 1'b1;
    else                exp_wel = ref_wel;
    @(posedge clk);
    #1;
    check(tag, "grant", grant, req && ok);
    check(tag, "reject", reject, req && !ok);
    check(req ? "R8" : "R1", "wel", wel, exp_wel);
    ref_wel = exp_wel;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, '0, 1, 3'd0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [ADDR_W-1:0] top;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    top = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R2", "wel in reset", wel, 0);
    check("R2", "grant in reset", grant, 0);
    check("R2", "reject in reset", reject, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R2", "wel after reset", wel, 0);
    check("R2", "reject after reset", reject, 0);

    // R4 latch clear
    step(0, 0, 1, 0, 0, '0, 1, 3'd0, 0);
    // R1 set, then program granted, auto clear R8
    step(1, 0, 0, 0, 0, '0, 1, 3'd0, 0);
    step(0, 0, 1, 0, 0, '0, 1, 3'd0, 0);
    // R1 wrdis wins over wren
    step(1, 1, 0, 0, 0, '0, 1, 3'd0, 0);
    // R8 wren with request in same cycle
    step(1, 0, 0, 0, 0, '0, 1, 3'd0, 0);
    step(1, 0, 0, 1, 0, '0, 1, 3'd0, 0);
    step(0, 0, 1, 0, 0, '0, 1, 3'd0, 0);
    // R5 pin asserted with latch set
    step(1, 0, 0, 0, 0, '0, 1, 3'd0, 0);
    step(0, 0, 1, 0, 0, '0, 0, 3'd0, 0);
    // R6 boundaries for each code
    for (int c = 1; c < 7; c++) begin
      logic [ADDR_W-1:0] edge_a;
      edge_a = top - ((ADDR_W)'(1) << (ADDR_W - 7 + c)) + 1'b1;
      step(1, 0, 0, 0, 0, '0, 1, 3'(c), 0);
      step(0, 0, 1, 0, 0, edge_a - 1'b1, 1, 3'(c), 0);
      step(1, 0, 0, 0, 0, '0, 1, 3'(c), 0);
      step(0, 0, 0, 1, 0, edge_a, 1, 3'(c), 0);
    end
    step(1, 0, 0, 0, 0, '0, 1, 3'd7, 0);
    step(0, 0, 1, 0, 0, '0, 1, 3'd7, 0);
    step(1, 0, 0, 0, 0, '0, 1, 3'd0, 0);
    step(0, 0, 1, 0, 0, top, 1, 3'd0, 0);
    // R7 cfg write ignores range, blocked by lock
    step(1, 0, 0, 0, 0, '0, 1, 3'd7, 0);
    step(0, 0, 0, 0, 1, top, 1, 3'd7, 0);
    step(1, 0, 0, 0, 0, '0, 1, 3'd0, 1);
    step(0, 0, 0, 0, 1, '0, 1, 3'd0, 1);
    // R9 stacked strobes
    step(1, 0, 0, 0, 0, '0, 1, 3'd0, 0);
    step(0, 0, 1, 0, 1, '0, 1, 3'd0, 0);
    idle();

    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom);
      if ($urandom_range(1, 0) == 1) a[ADDR_W-1 -: 6] = '1;
      step($urandom_range(99, 0) < 45, $urandom_range(99, 0) < 8,
           $urandom_range(99, 0) < 25, $urandom_range(99, 0) < 15,
           $urandom_range(99, 0) < 12, a,
           $urandom_range(99, 0) < 85, 3'($urandom_range(7, 0)),
           $urandom_range(99, 0) < 30);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule